// File: doc/BRIEF.md
# Watchdog Timer With Prescaler

This block is a watchdog counter that requests a system reset when software stops servicing it. A free-running binary counter advances once every 2^p clock cycles, where p is a 3-bit prescale selection from 0 to 7. When the counter wraps past its all-ones value, the block raises a one-cycle reset request. Software keeps the request from happening by writing a two-byte key to the key register: the byte 1Eh followed by the byte E1h as the next write on the register port. A correct key restarts both the counter and the prescaler from zero.

The prescale selection sits in its own register at offset 0Dh of the register window. A newly written selection is only copied into the running prescaler when the next valid key clear is accepted, so the timeout never changes halfway through an interval. A separate disable input holds the counter and prescaler at zero and blocks every request for as long as it is high. The chip's reset sequencing that acts on the request is outside this block.

Top module: `guard_timer`

## Requirements
- R1: While `rst_n` is low `rst_req` is low and the active prescale is 0; `rst_n` is released through a two-flop synchronizer, so with no write and `wd_off` low the first request appears 2^CNT_W + 2 rising edges after the falling edge on which `rst_n` went high.
- R2: A write to offset 0Dh stores `reg_wdata[2:0]` as the prescale selection p and ignores bits 7:3; once active, p sets the time from a clear to the next request to exactly 2^(CNT_W+p) rising edges, counted from the edge that accepted the clear.
- R3: A write to the prescale register does not change the running interval; the new p is only used from the next accepted clear onwards.
- R4: A clear is accepted on the edge that samples a write of E1h to the key register (offset 02h) when the previous write on the port was 1Eh to the key register; idle cycles between the two writes are allowed, and the clear restarts the counter and the prescaler at zero.
- R5: Any other write between 1Eh and E1h (another address, or other data) breaks the sequence, E1h alone clears nothing, and a repeated 1Eh keeps the sequence armed.
- R6: `rst_req` is high for exactly one cycle per wrap, and without a clear the requests repeat every 2^(CNT_W+p) edges.
- R7: While `wd_off` is high the counter and prescaler stay at zero and `rst_req` stays low; counting restarts from zero, so the next request arrives 2^(CNT_W+p) edges after the last edge that sampled `wd_off` high.
- R8: When a clear is accepted on the same edge as a wrap, the clear wins and no request is issued; a clear that lands one edge after the wrap does not cancel the request already issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Register offset within the window |
| reg_wdata | input | DATA_W | Register write data |
| wd_off | input | 1 | High holds the watchdog stopped and cleared |
| rst_req | output | 1 | One-cycle reset request on counter wrap |

## Verification
The key clear and the counter wrap can fall on the same clock edge, and the outcome then decides whether the system resets. The bench measures the edge of a clear, places the 1Eh write one edge before the wrap so that E1h is sampled on the wrap edge itself, and expects no request there and a full interval from that clear. It then repeats the sequence with the E1h write one edge late and expects the request to be issued before the clear restarts the count.

// File: rtl/gt_pkg.sv
package gt_pkg;

  // Key bytes of the two-write clear sequence
  localparam logic [7:0] KEY_FIRST  = 8'h1E;
  localparam logic [7:0] KEY_SECOND = 8'hE1;

  // Clear sequence state
  typedef enum logic {
    KS_IDLE  = 1'b0,
    KS_ARMED = 1'b1
  } key_state_e;

endpackage

// File: rtl/gt_rst_sync.sv
module gt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;

endmodule

// File: rtl/gt_regif.sv
module gt_regif
  import gt_pkg::*;
#(
  parameter int                 ADDR_W    = 4,
  parameter int                 DATA_W    = 8,
  parameter int                 PSEL_W    = 3,
  parameter logic [ADDR_W-1:0]  PSEL_ADDR = 4'hD,
  parameter logic [ADDR_W-1:0]  KEY_ADDR  = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [PSEL_W-1:0] psel_q,
  output logic              clr
);

  localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
  localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);

  key_state_e        key_q, key_d;
  logic [PSEL_W-1:0] psel_d;
  logic              psel_en;
  logic              hit_psel;
  logic              hit_key;

  always_comb begin
    hit_psel = we && (addr == PSEL_ADDR);
    hit_key  = we && (addr == KEY_ADDR);

    // Prescale selection register, clock enable on its own write
    psel_en = hit_psel;
    psel_d  = wdata[PSEL_W-1:0];

    // Key sequence: every write decides the next state, idle cycles keep it
    key_d = key_q;
    if (we) begin
      key_d = (hit_key && (wdata == K1)) ? KS_ARMED : KS_IDLE;
    end

    clr = hit_key && (wdata == K2) && (key_q == KS_ARMED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= KS_IDLE;
    end else begin
      key_q <= key_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psel_q <= '0;
    end else if (psel_en) begin
      psel_q <= psel_d;
    end
  end

endmodule

// File: rtl/gt_prescaler.sv
module gt_prescaler #(
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic [PSEL_W-1:0] psel_q,
  output logic [PSEL_W-1:0] psel_act,
  output logic              tick
);

  localparam int PCNT_W = (1 << PSEL_W) - 1;

  logic [PCNT_W-1:0] pcnt_q, pcnt_d;
  logic [PCNT_W-1:0] mask;
  logic [PSEL_W-1:0] act_d;
  logic              act_en;

  // One mask bit per prescaler stage: stage i is used when p > i
  for (genvar i = 0; i < PCNT_W; i++) begin : g_mask
    assign mask[i] = (psel_act > PSEL_W'(i));
  end

  always_comb begin
    tick   = en && ((pcnt_q & mask) == mask);
    act_en = clr;
    act_d  = psel_q;
    if (clr || !en) begin
      pcnt_d = '0;
    end else begin
      pcnt_d = pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psel_act <= '0;
    end else if (act_en) begin
      psel_act <= act_d;
    end
  end

endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             req_q
);

  logic [CNT_W-1:0] cnt_d;
  logic             req_d;
  logic             at_top;

  always_comb begin
    at_top = (cnt_q == '1);
    cnt_d  = cnt_q;
    req_d  = 1'b0;
    if (clr || !en) begin
      // Clear and disable win over a wrap on the same edge
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
      req_d = at_top;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int                CNT_W     = 16,
  parameter int                PSEL_W    = 3,
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] PSEL_ADDR = 4'hD,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              wd_off,
  output logic              rst_req
);

  logic              rst_int_n;
  logic              run_en;
  logic              clr;
  logic              tick;
  logic [PSEL_W-1:0] psel_q;
  logic [PSEL_W-1:0] psel_act;
  logic [CNT_W-1:0]  cnt_q;

  assign run_en = !wd_off;

  gt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  gt_regif #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PSEL_W    (PSEL_W),
    .PSEL_ADDR (PSEL_ADDR),
    .KEY_ADDR  (KEY_ADDR)
  ) u_regif (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .psel_q (psel_q),
    .clr    (clr)
  );

  gt_prescaler #(
    .PSEL_W (PSEL_W)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (run_en),
    .clr      (clr),
    .psel_q   (psel_q),
    .psel_act (psel_act),
    .tick     (tick)
  );

  gt_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (run_en),
    .clr   (clr),
    .tick  (tick),
    .cnt_q (cnt_q),
    .req_q (rst_req)
  );

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
  parameter int                CNT_W     = 16,
  parameter int                PSEL_W    = 3,
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] PSEL_ADDR = 4'hD
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              wd_off,
  input logic              rst_req,
  input logic              clr,
  input logic              tick,
  input logic [PSEL_W-1:0] psel_q,
  input logic [PSEL_W-1:0] psel_act,
  input logic [CNT_W-1:0]  cnt_q
);

  // R6
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rst_req |=> !rst_req);

  // R7
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    wd_off |=> (!rst_req && (cnt_q == '0)));

  // R4
  clear_restart_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    clr |=> (cnt_q == '0));

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    clr |=> !rst_req);

  // R2
  psel_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_we && (reg_addr == PSEL_ADDR)) |=> (psel_q == $past(reg_wdata[PSEL_W-1:0])));

  // R3
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !clr |=> $stable(psel_act));

  // R2
  count_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!tick && !clr && !wd_off) |=> $stable(cnt_q));

endmodule

bind guard_timer guard_timer_chk #(
  .CNT_W     (CNT_W),
  .PSEL_W    (PSEL_W),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PSEL_ADDR (PSEL_ADDR)
) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .wd_off    (wd_off),
  .rst_req   (rst_req),
  .clr       (clr),
  .tick      (tick),
  .psel_q    (psel_q),
  .psel_act  (psel_act),
  .cnt_q     (cnt_q)
);

// File: tb/sim_guard_timer.sv
`timescale 1ns/1ps
module sim_guard_timer;

  localparam int         CW    = 8;
  localparam logic [3:0] A_PS  = 4'hD;
  localparam logic [3:0] A_KEY = 4'h2;

  logic       clk;
  logic       rst_n;
  logic       reg_we;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       wd_off;
  logic       rst_req;

  int cyc;
  int n_chk;
  int n_bad;
  int lw;

  guard_timer #(.CNT_W(CW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .wd_off    (wd_off),
    .rst_req   (rst_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next rising edge, returns at the next negedge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_we    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    lw     = cyc;
  endtask

  task automatic do_clear();
    wr(A_KEY, 8'h1E);
    wr(A_KEY, 8'hE1);
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  // Waits for the next request, checks its distance from t0 and its one-cycle width
  task automatic wait_req(input int t0, input int exp, input string tag, output int treq);
    do @(negedge clk); while (!rst_req && ((cyc - t0) < exp + 4));
    treq = cyc;
    chk(rst_req && ((cyc - t0) == exp), tag, cyc - t0, exp);
    @(negedge clk);
    chk(!rst_req, "R6 pulse width", int'(rst_req), 0);
  endtask

  task automatic t_reset();
    int t0, tr, tr2;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; wd_off = 1'b0;
    repeat (4) @(negedge clk);
    chk(!rst_req, "R1 request low in reset", int'(rst_req), 0);
    t0 = cyc;
    rst_n = 1'b1;
    wait_req(t0, (1 << CW) + 2, "R1 first request after reset", tr);
    wait_req(tr, 1 << CW, "R6 repeat period", tr2);
  endtask

  task automatic t_prescale();
    int tc, tr;
    do_clear(); tc = lw;
    wr(A_PS, 8'hFA);                       // p = 2, upper bits ignored
    wait_req(tc, 1 << CW, "R3 new prescale not yet active", tr);
    do_clear(); tc = lw;
    wait_req(tc, 1 << (CW + 2), "R2 prescale 2", tr);
    wr(A_PS, 8'h07);
    do_clear(); tc = lw;
    wait_req(tc, 1 << (CW + 7), "R2 prescale 7", tr);
    wr(A_PS, 8'h00);
    do_clear(); tc = lw;
    wait_req(tc, 1 << CW, "R2 prescale 0", tr);
  endtask

  task automatic t_keys();
    int tc, tr;
    do_clear(); tc = lw;
    wr(A_KEY, 8'h1E);
    wr(A_PS, 8'h00);
    wr(A_KEY, 8'hE1);                      // broken by the write in between
    wr(A_KEY, 8'hE1);                      // lone second byte
    wr(A_KEY, 8'h1E);
    wr(A_KEY, 8'h55);
    wr(A_KEY, 8'hE1);                      // broken by wrong data
    wait_req(tc, 1 << CW, "R5 broken sequences do not clear", tr);
    wr(A_KEY, 8'h1E);
    wr(A_KEY, 8'h1E);
    wr(A_KEY, 8'hE1); tc = lw;
    wait_req(tc, 1 << CW, "R5 repeated first byte stays armed", tr);
    wr(A_KEY, 8'h1E);
    repeat (5) @(negedge clk);
    wr(A_KEY, 8'hE1); tc = lw;
    wait_req(tc, 1 << CW, "R4 clear with idle gap", tr);
  endtask

  task automatic t_disable();
    int hits, t0, tr;
    hits = 0;
    wd_off = 1'b1;
    repeat (600) begin
      @(negedge clk);
      if (rst_req) hits++;
    end
    chk(hits == 0, "R7 no request while disabled", hits, 0);
    t0 = cyc;
    wd_off = 1'b0;
    wait_req(t0, 1 << CW, "R7 restart from zero", tr);
  endtask

  task automatic t_collide();
    int tc, tr;
    do_clear(); tc = lw;
    wait_until(tc + (1 << CW) - 2);
    wr(A_KEY, 8'h1E);
    wr(A_KEY, 8'hE1);
    chk(lw == tc + (1 << CW), "R8 clear on wrap edge placed", lw - tc, 1 << CW);
    chk(!rst_req, "R8 clear wins over wrap", int'(rst_req), 0);
    tc = lw;
    wait_req(tc, 1 << CW, "R8 interval after winning clear", tr);
    do_clear(); tc = lw;
    wait_until(tc + (1 << CW) - 1);
    wr(A_KEY, 8'h1E);
    chk(rst_req, "R8 late clear keeps request", int'(rst_req), 1);
    wr(A_KEY, 8'hE1); tc = lw;
    wait_req(tc, 1 << CW, "R4 interval after late clear", tr);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    lw    = 0;
    t_reset();
    t_prescale();
    t_keys();
    t_disable();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule